// File: doc/BRIEF.md
# Repeater Hash Message Packer

This block turns a repeater's downstream device-key list and its two-byte topology status into the word stream that a 32-bit SHA-1 style hash engine consumes. Bytes arrive one at a time on a valid/ready input. The block packs them most-significant byte first into 32-bit words. Because each key is five bytes long, key bytes run across word boundaries. Each output word carries a text-byte count. The engine fills every byte of a word not covered by that count with its own eight-byte hidden secret. The mix of text words and secret words after the last key therefore depends on how many key bytes were left over in the last partial word.

When the text and the secret are done, the block adds zero words until the byte offset within the current 64-byte block reaches 60. It then sends a final word that gives the message length in bits. It raises a hash-completion request and waits for the engine to answer. It reports match, mismatch or timeout as a single result pulse. Every wait for the engine is bounded by a cycle timeout.

Top module: `rep_hash_packer`

## Requirements
- R1: Key and status bytes are packed most-significant byte first into 32-bit words. Each word made only of text carries `word_tbytes` = 4, which means 32 text bits.
- R2: When the text ends partway through a word, that word carries its text right-aligned in the low bytes, with zeros above. Its `word_tbytes` equals the number of text bytes it holds, from 1 to 3.
- R3: Eight secret bytes follow the text. A word made only of secret has `word_tbytes` = 0. The last word holding secret has `word_tbytes` = 4 minus the secret bytes it holds. All of these words carry data 0.
- R4: Let L be the number of key bytes left in the last partial word (5·N mod 4). The `word_tbytes` sequence from the word holding the first status byte to the end of the secret is: {2,0,2} for L=0, {3,0,1} for L=1, {4,0,0} for L=2, and {4,1,0,3} for L=3.
- R5: After the secret, zero words with `word_tbytes` = 4 are sent until the byte offset of the next word, taken modulo 64, equals 60.
- R6: The last word has `word_tbytes` = 4 and value (N·5 + 10)·8.
- R7: `seg_first` is high together with a valid word exactly when that word's byte offset in the stream is a multiple of 64.
- R8: A word offered on `word_valid` keeps its data and count until `word_ready` accepts it. `in_ready` is low while a word is pending.
- R9: After the length word is accepted, `hash_req` stays high until `hash_done`. `res_valid` then pulses for one cycle, with `res_match` = `hash_match` and `res_timeout` = 0.
- R10: If a word waits unaccepted for TIMEOUT cycles, or `hash_req` waits for `hash_done` for TIMEOUT cycles, the run aborts. `res_valid` pulses with `res_timeout` = 1 and `res_match` = 0.
- R11: The number of bytes held in the packing register between words never leaves the range 0 to 3.
- R12: After reset, `word_valid`, `in_ready`, `hash_req`, `busy` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a message; taken only while idle |
| num_keys | input | NK_W | Number of downstream device keys N |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Key bytes, then the two status bytes |
| in_ready | output | 1 | Block accepts an input byte |
| word_valid | output | 1 | Word offered to the hash engine |
| word_data | output | 32 | Word value |
| word_tbytes | output | 3 | Text bytes in the word (0 to 4) |
| seg_first | output | 1 | Word opens a 64-byte block |
| word_ready | input | 1 | Engine ready, word accepted |
| hash_req | output | 1 | Request to finish the hash |
| hash_done | input | 1 | Engine finished the hash |
| hash_match | input | 1 | Engine compare result, sampled with hash_done |
| busy | output | 1 | A message is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_match | output | 1 | Hash matched |
| res_timeout | output | 1 | Run aborted on a timeout |

## Verification
A wrong leftover count or a wrong secret-bytes count first shows up in the `word_tbytes` of the words just after the status bytes. Those words appear within a few cycles of the last input byte. A wrong byte offset shows up later: the pad-word count is wrong, `seg_first` lands on the wrong word, and the length word arrives in the wrong slot. The bench compares every accepted word, its count and its `seg_first` flag against a sequence rebuilt from byte positions, so the first wrong word is reported in the cycle it is accepted. A wrong timer shows up as a timeout pulse whose offered-word or request window differs from TIMEOUT cycles.

// File: rtl/rhp_pkg.sv
package rhp_pkg;

  localparam int KEY_BYTES    = 5;
  localparam int STAT_BYTES   = 2;
  localparam int SECRET_BYTES = 8;
  localparam int WORD_BYTES   = 4;
  localparam int SEG_BYTES    = 64;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TEXT,
    PH_SECRET,
    PH_TAIL,
    PH_DONE
  } seq_phase_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_WORDS,
    CT_HASH
  } ctl_state_e;

  // bytes of real text entering on the byte input for n keys
  function automatic logic [31:0] text_bytes(input logic [31:0] n);
    return n * 32'(KEY_BYTES) + 32'(STAT_BYTES);
  endfunction

  // message length in bits reported in the closing word
  function automatic logic [31:0] length_bits(input logic [31:0] n);
    return (n * 32'(KEY_BYTES) + 32'(STAT_BYTES + SECRET_BYTES)) << 3;
  endfunction

  // secret bytes still owed after the word that closes the text
  function automatic logic [3:0] secret_after(input logic [2:0] held);
    return 4'(SECRET_BYTES - WORD_BYTES) + {1'b0, held};
  endfunction

  // text count of the word that carries the last secret bytes
  function automatic logic [2:0] tail_text(input logic [3:0] sec_left);
    return 3'(4'(WORD_BYTES) - sec_left);
  endfunction

endpackage

// File: rtl/rhp_word_seq.sv
module rhp_word_seq
  import rhp_pkg::*;
#(
  parameter int NK_W = 8,
  localparam int TXT_W = NK_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic [NK_W-1:0] num_keys,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            in_ready,
  input  logic            take,
  output logic            word_pend,
  output logic [31:0]     word_data,
  output logic [2:0]      word_tbytes,
  output logic            seg_first,
  output logic            seq_done,
  output logic [2:0]      carry_cnt
);

  seq_phase_e       phase;
  logic [31:0]      acc;
  logic [2:0]       cnt;
  logic [TXT_W-1:0] txt_left;
  logic [3:0]       sec_left;
  logic [5:0]       idx;
  logic [NK_W-1:0]  nkeys;
  logic             pend;
  logic [31:0]      pw;
  logic [2:0]       pc;

  logic        byte_fire;
  logic [2:0]  ncnt;
  logic [31:0] nacc;
  logic        last_byte;

  assign in_ready  = (phase == PH_TEXT) && !pend;
  assign byte_fire = in_valid && in_ready;
  assign ncnt      = cnt + 3'd1;
  assign nacc      = {acc[23:0], in_byte};
  assign last_byte = (txt_left == TXT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      acc      <= '0;
      cnt      <= '0;
      txt_left <= '0;
      sec_left <= '0;
      idx      <= '0;
      nkeys    <= '0;
      pend     <= 1'b0;
      pw       <= '0;
      pc       <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
      pend  <= 1'b0;
      acc   <= '0;
      cnt   <= '0;
    end else if (start) begin
      phase    <= PH_TEXT;
      txt_left <= TXT_W'(text_bytes(32'(num_keys)));
      nkeys    <= num_keys;
      acc      <= '0;
      cnt      <= '0;
      idx      <= '0;
      pend     <= 1'b0;
    end else begin
      if (take) begin
        pend <= 1'b0;
        idx  <= idx + 6'd4;
      end
      case (phase)
        PH_TEXT: begin
          if (byte_fire) begin
            txt_left <= txt_left - TXT_W'(1);
            if (ncnt == 3'd4 || last_byte) begin
              pend <= 1'b1;
              pw   <= nacc;
              pc   <= ncnt;
              acc  <= '0;
              cnt  <= '0;
              if (last_byte) begin
                phase    <= PH_SECRET;
                sec_left <= secret_after(ncnt);
              end
            end else begin
              acc <= nacc;
              cnt <= ncnt;
            end
          end
        end
        PH_SECRET: begin
          if (!pend) begin
            pend <= 1'b1;
            pw   <= '0;
            if (sec_left > 4'd4) begin
              pc       <= 3'd0;
              sec_left <= sec_left - 4'd4;
            end else begin
              pc    <= tail_text(sec_left);
              phase <= PH_TAIL;
            end
          end
        end
        PH_TAIL: begin
          if (!pend) begin
            pend <= 1'b1;
            pc   <= 3'd4;
            if (idx == 6'(SEG_BYTES - WORD_BYTES)) begin
              pw    <= length_bits(32'(nkeys));
              phase <= PH_DONE;
            end else begin
              pw <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign word_pend   = pend;
  assign word_data   = pw;
  assign word_tbytes = pc;
  assign seg_first   = pend && (idx == 6'd0);
  assign seq_done    = (phase == PH_DONE) && !pend;
  assign carry_cnt   = cnt;

endmodule

// File: rtl/rhp_wait_timer.sv
module rhp_wait_timer #(
  parameter int TIMEOUT = 64,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          waiting,
  output logic          expire,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt;

  assign expire = waiting && (cnt == CW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!waiting || expire) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign count = cnt;

endmodule

// File: rtl/rep_hash_packer.sv
module rep_hash_packer
  import rhp_pkg::*;
#(
  parameter int NK_W    = 8,
  parameter int TIMEOUT = 64,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NK_W-1:0] num_keys,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            in_ready,
  output logic            word_valid,
  output logic [31:0]     word_data,
  output logic [2:0]      word_tbytes,
  output logic            seg_first,
  input  logic            word_ready,
  output logic            hash_req,
  input  logic            hash_done,
  input  logic            hash_match,
  output logic            busy,
  output logic            res_valid,
  output logic            res_match,
  output logic            res_timeout
);

  ctl_state_e    ctl;
  logic          seq_start;
  logic          seq_pend;
  logic          seq_done;
  logic          seq_seg;
  logic [2:0]    seq_carry;
  logic          take;
  logic          waiting;
  logic          expire;
  logic [CW-1:0] tmr_cnt;

  assign seq_start  = start && (ctl == CT_IDLE);
  assign word_valid = seq_pend && (ctl == CT_WORDS);
  assign seg_first  = seq_seg && (ctl == CT_WORDS);
  assign take       = word_valid && word_ready;
  assign hash_req   = (ctl == CT_HASH);
  assign waiting    = (word_valid && !word_ready) || (hash_req && !hash_done);
  assign busy       = (ctl != CT_IDLE);

  rhp_word_seq #(.NK_W(NK_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (seq_start),
    .abort       (expire),
    .num_keys    (num_keys),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .in_ready    (in_ready),
    .take        (take),
    .word_pend   (seq_pend),
    .word_data   (word_data),
    .word_tbytes (word_tbytes),
    .seg_first   (seq_seg),
    .seq_done    (seq_done),
    .carry_cnt   (seq_carry)
  );

  rhp_wait_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (waiting),
    .expire  (expire),
    .count   (tmr_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl         <= CT_IDLE;
      res_valid   <= 1'b0;
      res_match   <= 1'b0;
      res_timeout <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (ctl)
        CT_IDLE: begin
          if (start) begin
            ctl         <= CT_WORDS;
            res_match   <= 1'b0;
            res_timeout <= 1'b0;
          end
        end
        CT_WORDS: begin
          if (expire) begin
            ctl         <= CT_IDLE;
            res_valid   <= 1'b1;
            res_timeout <= 1'b1;
          end else if (seq_done) begin
            ctl <= CT_HASH;
          end
        end
        CT_HASH: begin
          if (hash_done) begin
            ctl       <= CT_IDLE;
            res_valid <= 1'b1;
            res_match <= hash_match;
          end else if (expire) begin
            ctl         <= CT_IDLE;
            res_valid   <= 1'b1;
            res_timeout <= 1'b1;
          end
        end
        default: ctl <= CT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rhp_checker.sv
module rhp_checker #(
  parameter int TIMEOUT = 64,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          word_valid,
  input logic [31:0]   word_data,
  input logic [2:0]    word_tbytes,
  input logic          word_ready,
  input logic          hash_req,
  input logic          busy,
  input logic          res_valid,
  input logic          res_match,
  input logic          res_timeout,
  input logic [2:0]    carry_cnt,
  input logic [CW-1:0] tmr_cnt
);

  // R11
  carry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_cnt <= 3'd3);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && tmr_cnt != CW'(TIMEOUT - 1))
      |=> (word_valid && $stable(word_data) && $stable(word_tbytes)));

  // R8
  input_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !in_ready);

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_tbytes <= 3'd4);

  // R9
  req_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_req |-> (!word_valid && !in_ready && busy));

  // R9
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R10
  res_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_match && res_timeout));

  // R10
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cnt < CW'(TIMEOUT));

endmodule

bind rep_hash_packer rhp_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .word_valid  (word_valid),
  .word_data   (word_data),
  .word_tbytes (word_tbytes),
  .word_ready  (word_ready),
  .hash_req    (hash_req),
  .busy        (busy),
  .res_valid   (res_valid),
  .res_match   (res_match),
  .res_timeout (res_timeout),
  .carry_cnt   (seq_carry),
  .tmr_cnt     (tmr_cnt)
);

// File: tb/tb_rep_hash_packer.sv
module tb_rep_hash_packer;

  localparam int NK_W = 8;
  localparam int TMO  = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [NK_W-1:0] num_keys;
  logic            in_valid;
  logic [7:0]      in_byte;
  logic            in_ready;
  logic            word_valid;
  logic [31:0]     word_data;
  logic [2:0]      word_tbytes;
  logic            seg_first;
  logic            word_ready;
  logic            hash_req;
  logic            hash_done;
  logic            hash_match;
  logic            busy;
  logic            res_valid;
  logic            res_match;
  logic            res_timeout;

  always #10 clk = ~clk;

  rep_hash_packer #(.NK_W(NK_W), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_keys(num_keys),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .word_valid(word_valid), .word_data(word_data), .word_tbytes(word_tbytes),
    .seg_first(seg_first), .word_ready(word_ready), .hash_req(hash_req),
    .hash_done(hash_done), .hash_match(hash_match), .busy(busy),
    .res_valid(res_valid), .res_match(res_match), .res_timeout(res_timeout)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [7:0]  txt   [0:1023];
  logic [31:0] exp_d [0:511];
  logic [2:0]  exp_c [0:511];
  int          exp_k [0:511];
  int          exp_n;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Rebuild the word list from byte positions: text, then secret, then
  // zero text, then zero padding, then the bit length.
  task automatic build_exp(input int n);
    int t;
    int nw;
    int idx;
    t = 5 * n + 2;
    nw = (t + 8 + 3) / 4;
    exp_n = 0;
    for (int k = 0; k < nw; k++) begin
      logic [31:0] d;
      int c;
      d = 0;
      c = 0;
      for (int j = 0; j < 4; j++) begin
        int p;
        p = 4 * k + j;
        if (p < t) begin
          d = (d << 8) | 32'(txt[p]);
          c++;
        end else if (p >= t + 8) begin
          c++;
        end
      end
      exp_d[exp_n] = d;
      exp_c[exp_n] = 3'(c);
      exp_k[exp_n] = (4 * k + 4 <= t) ? 1 : 3;
      exp_n++;
    end
    idx = 4 * nw;
    while ((idx % 64) != 60) begin
      exp_d[exp_n] = 0; exp_c[exp_n] = 3'd4; exp_k[exp_n] = 5;
      exp_n++;
      idx += 4;
    end
    exp_d[exp_n] = 32'((5 * n + 10) * 8);
    exp_c[exp_n] = 3'd4;
    exp_k[exp_n] = 6;
    exp_n++;
  endtask

  // mode 0: normal, 1: word never accepted, 2: hash never completes
  task automatic run_msg(input int n, input bit match, input int mode);
    int t, bp, wi, vcnt, hcnt;
    bit got, rm, rt, prev_pend;
    logic [31:0] prev_d;
    t = 5 * n + 2;
    for (int i = 0; i < t; i++) txt[i] = 8'($urandom);
    build_exp(n);
    @(negedge clk);
    start = 1'b1;
    num_keys = NK_W'(n);
    @(negedge clk);
    start = 1'b0;
    bp = 0; wi = 0; vcnt = 0; hcnt = 0; got = 0; rm = 0; rt = 0;
    prev_pend = 0; prev_d = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      if (res_valid) begin
        got = 1; rm = res_match; rt = res_timeout;
        break;
      end
      if (word_valid) vcnt++;
      if (hash_req) hcnt++;
      if (word_valid) chk(!in_ready, "R8 in_ready while word pending", 64'(in_ready), 0);
      if (prev_pend && word_valid)
        chk(word_data == prev_d, "R8 word held until accepted", 64'(word_data), 64'(prev_d));
      in_valid = (bp < t) && ($urandom % 4 != 0);
      in_byte = (bp < t) ? txt[bp] : 8'h00;
      if (in_valid && in_ready) bp++;
      word_ready = (mode == 1) ? 1'b0 : ($urandom % 3 != 0);
      prev_pend = word_valid && !word_ready;
      prev_d = word_data;
      if (word_valid && word_ready) begin
        if (wi < exp_n) begin
          string tag;
          case (exp_k[wi])
            1: tag = "R1 full text word";
            3: tag = "R2 R3 R4 R11 tail word";
            5: tag = "R5 pad word";
            default: tag = "R6 length word";
          endcase
          chk(word_data == exp_d[wi], tag, 64'(word_data), 64'(exp_d[wi]));
          chk(word_tbytes == exp_c[wi], {tag, " count"}, 64'(word_tbytes), 64'(exp_c[wi]));
          chk(seg_first == ((wi % 16) == 0), "R7 seg_first", 64'(seg_first),
              64'((wi % 16) == 0));
        end else begin
          chk(0, "R6 extra word", 64'(wi), 64'(exp_n));
        end
        wi++;
      end
      hash_done = (mode != 2) && hash_req && ($urandom % 2 == 0);
      hash_match = match;
      @(negedge clk);
    end
    in_valid = 0; word_ready = 0; hash_done = 0;
    chk(got, "R9 result pulse seen", 64'(got), 1);
    if (mode == 0) begin
      chk(wi == exp_n, "R5 R6 word count", 64'(wi), 64'(exp_n));
      chk(rm == match, "R9 match reported", 64'(rm), 64'(match));
      chk(!rt, "R9 no timeout", 64'(rt), 0);
    end else if (mode == 1) begin
      chk(vcnt == TMO, "R10 word wait window", 64'(vcnt), 64'(TMO));
      chk(rt && !rm, "R10 word timeout result", 64'({rt, rm}), 64'(2));
    end else begin
      chk(wi == exp_n, "R10 words before hash wait", 64'(wi), 64'(exp_n));
      chk(hcnt == TMO, "R10 hash wait window", 64'(hcnt), 64'(TMO));
      chk(rt && !rm, "R10 hash timeout result", 64'({rt, rm}), 64'(2));
    end
    @(negedge clk);
    chk(!busy && !res_valid, "R9 idle after result", 64'({busy, res_valid}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_val;
    seed_val = int'($urandom(32'd20240517));
    rst_n = 0; start = 0; num_keys = '0; in_valid = 0; in_byte = '0;
    word_ready = 0; hash_done = 0; hash_match = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!word_valid && !in_ready && !hash_req && !busy && !res_valid, "R12 reset state",
        64'({word_valid, in_ready, hash_req, busy, res_valid}), 0);
    // leftover 1, 2, 3, 0
    run_msg(1, 1, 0);
    run_msg(2, 1, 0);
    run_msg(3, 1, 0);
    run_msg(4, 1, 0);
    run_msg(4, 0, 0);
    // tail ends exactly at offset 60, no padding
    run_msg(10, 1, 0);
    // crossing 64-byte blocks
    run_msg(12, 1, 0);
    run_msg(13, 0, 0);
    run_msg(25, 1, 0);
    for (int r = 0; r < 6; r++) run_msg(1 + int'($urandom % 40), 1'($urandom), 0);
    run_msg(2, 1, 1);
    run_msg(3, 1, 2);
    run_msg(5, 1, 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule